// File: doc/BRIEF.md
# Configurable IO Path Storage Element

This block is the storage element that sits on one data path of an IO cell. One copy serves the input path, one the output path and one the enable path of the pad driver. Because each path has its own element, the path does not need a register in the core logic. The element needs no setup time from a logic block on inputs, and it shortens clock-to-pad on outputs.

Static configuration inputs turn the element into an edge-triggered flip-flop or a level-sensitive latch. They set the active polarity of the clock, the clock enable and the set/reset input. They choose whether set/reset acts at once or only on the clock, and whether it loads ones or zeros. A bypass setting sends the data input straight to the output, so the path is purely combinational. The flip-flop and the latch are both always present, and the mode setting picks which one drives the output.

Top module: `io_path_reg`

## Requirements
- R1: In flip-flop mode with `cfg_clk_inv_i`=0, `dout_o` takes `din_i` on each rising edge of `clk_i` when the enable is active. With the enable inactive it keeps its value, and it does not change between edges.
- R2: With `cfg_clk_inv_i`=1, the flip-flop captures on the falling edge of `clk_i` and the latch is transparent while `clk_i` is low. With `cfg_clk_inv_i`=0 the latch is transparent while `clk_i` is high.
- R3: The enable is active when `en_i` differs from `cfg_en_inv_i`, so `cfg_en_inv_i`=1 makes `en_i`=0 the enabling level.
- R4: In latch mode (`cfg_latch_i`=1), `dout_o` follows `din_i` while the clock level is active and the enable is active. Otherwise it holds its last value.
- R5: Set/reset is active when `sr_i` differs from `cfg_sr_inv_i`.
- R6: In flip-flop mode with synchronous set/reset (`cfg_sr_async_i`=0), an active set/reset on the capturing edge loads the init value. It does this whatever the enable is, and it takes priority over `din_i`.
- R7: In latch mode with synchronous set/reset, an active set/reset loads the init value only while the latch is transparent. It has no effect while the latch is closed.
- R8: With `cfg_sr_async_i`=1, an active set/reset forces `dout_o` to the init value at once, with no clock edge, in either mode. After release the value is held until the next capture. With every bit cleared, this is the power-up state.
- R9: The init value is all ones when `cfg_sr_set_i`=1 and all zeros when `cfg_sr_set_i`=0.
- R10: With `cfg_bypass_i`=1, `dout_o` equals `din_i` combinationally, and the stored value has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Path clock, polarity set by cfg_clk_inv_i |
| en_i | input | 1 | Clock enable, polarity set by cfg_en_inv_i |
| sr_i | input | 1 | Set/reset request, polarity set by cfg_sr_inv_i |
| din_i | input | WIDTH | Data from the pad or the core |
| cfg_latch_i | input | 1 | 1 = level-sensitive latch, 0 = edge-triggered flip-flop |
| cfg_clk_inv_i | input | 1 | 1 = falling edge / low level is active |
| cfg_en_inv_i | input | 1 | 1 = enable active low |
| cfg_sr_inv_i | input | 1 | 1 = set/reset active low |
| cfg_sr_async_i | input | 1 | 1 = set/reset acts immediately, 0 = on the clock |
| cfg_sr_set_i | input | 1 | 1 = set/reset loads ones, 0 = loads zeros |
| cfg_bypass_i | input | 1 | 1 = output driven directly by din_i |
| dout_o | output | WIDTH | Path output |

## Verification
The properties assume that the configuration inputs are static between clock edges and change only at a point away from any edge. Changing the clock or set/reset polarity creates a real edge on the internal clock or set/reset net, so the stored value is undefined until the next capture. The edge properties therefore hold only across two samples with an unchanged configuration, and the latch property is sampled at the falling edge, when the latch has just been open. The stimulus drives data, enable, set/reset and any new configuration half a nanosecond after a falling edge, and never on an edge. After a configuration change, its reference model counts each stored value as unknown until an enable or set/reset loads it again.

// File: rtl/iodreg_pkg.sv
package iodreg_pkg;

    // Static per-path configuration, gathered from the top-level pins.
    typedef struct packed {
        logic latch_mode;   // 1: level-sensitive, 0: edge-triggered
        logic clk_inv;      // active clock edge/level inverted
        logic en_inv;       // enable active low
        logic sr_inv;       // set/reset active low
        logic sr_async;     // set/reset acts without the clock
        logic sr_value;     // value loaded by set/reset
        logic bypass;       // combinational path
    } iodreg_cfg_t;

endpackage

// File: rtl/iodreg_ctrl.sv
module iodreg_ctrl
    import iodreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             en_i,
    input  logic             sr_i,
    input  iodreg_cfg_t      cfg_i,
    output logic             eff_clk_o,
    output logic             en_act_o,
    output logic             sr_act_o,
    output logic             async_hit_o,
    output logic [WIDTH-1:0] init_val_o
);

    // Normalise every control to an active-high meaning.
    always_comb begin
        eff_clk_o   = clk_i ^ cfg_i.clk_inv;
        en_act_o    = en_i ^ cfg_i.en_inv;
        sr_act_o    = sr_i ^ cfg_i.sr_inv;
        async_hit_o = cfg_i.sr_async & sr_act_o;
    end

    // Replicate the set/clear choice across the data width.
    for (genvar b = 0; b < WIDTH; b++) begin : g_init
        assign init_val_o[b] = cfg_i.sr_value;
    end

endmodule

// File: rtl/iodreg_flop.sv
module iodreg_flop #(
    parameter int WIDTH = 8
) (
    input  logic             eff_clk_i,
    input  logic             async_hit_i,
    input  logic             en_act_i,
    input  logic             sr_act_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] init_val_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] q;
    } flop_state_t;

    flop_state_t st_d, st_q;

    // Synchronous set/reset outranks data and ignores the enable.
    always_comb begin
        st_d = st_q;
        if (sr_act_i) begin
            st_d.q = init_val_i;
        end else if (en_act_i) begin
            st_d.q = din_i;
        end
    end

    always_ff @(posedge eff_clk_i or posedge async_hit_i) begin
        if (async_hit_i) begin
            st_q.q <= init_val_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/iodreg_latch.sv
module iodreg_latch #(
    parameter int WIDTH = 8
) (
    input  logic             level_i,
    input  logic             async_hit_i,
    input  logic             en_act_i,
    input  logic             sr_act_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] init_val_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic             load;
        logic [WIDTH-1:0] val;
    } latch_next_t;

    latch_next_t lat_d;
    logic [WIDTH-1:0] lat_q;

    // The load decision is computed without feedback from the stored value.
    always_comb begin
        lat_d.load = sr_act_i | en_act_i;
        lat_d.val  = sr_act_i ? init_val_i : din_i;
    end

    always_latch begin
        if (async_hit_i) begin
            lat_q <= init_val_i;
        end else if (level_i && lat_d.load) begin
            lat_q <= lat_d.val;
        end
    end

    assign q_o = lat_q;

endmodule

// File: rtl/io_path_reg.sv
module io_path_reg
    import iodreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             en_i,
    input  logic             sr_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             cfg_latch_i,
    input  logic             cfg_clk_inv_i,
    input  logic             cfg_en_inv_i,
    input  logic             cfg_sr_inv_i,
    input  logic             cfg_sr_async_i,
    input  logic             cfg_sr_set_i,
    input  logic             cfg_bypass_i,
    output logic [WIDTH-1:0] dout_o
);

    iodreg_cfg_t      cfg;
    logic             eff_clk;
    logic             en_act;
    logic             sr_act;
    logic             async_hit;
    logic [WIDTH-1:0] init_val;
    logic [WIDTH-1:0] flop_q;
    logic [WIDTH-1:0] latch_q;

    always_comb begin
        cfg.latch_mode = cfg_latch_i;
        cfg.clk_inv    = cfg_clk_inv_i;
        cfg.en_inv     = cfg_en_inv_i;
        cfg.sr_inv     = cfg_sr_inv_i;
        cfg.sr_async   = cfg_sr_async_i;
        cfg.sr_value   = cfg_sr_set_i;
        cfg.bypass     = cfg_bypass_i;
    end

    iodreg_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk_i       (clk_i),
        .en_i        (en_i),
        .sr_i        (sr_i),
        .cfg_i       (cfg),
        .eff_clk_o   (eff_clk),
        .en_act_o    (en_act),
        .sr_act_o    (sr_act),
        .async_hit_o (async_hit),
        .init_val_o  (init_val)
    );

    iodreg_flop #(.WIDTH(WIDTH)) u_flop (
        .eff_clk_i   (eff_clk),
        .async_hit_i (async_hit),
        .en_act_i    (en_act),
        .sr_act_i    (sr_act),
        .din_i       (din_i),
        .init_val_i  (init_val),
        .q_o         (flop_q)
    );

    iodreg_latch #(.WIDTH(WIDTH)) u_latch (
        .level_i     (eff_clk),
        .async_hit_i (async_hit),
        .en_act_i    (en_act),
        .sr_act_i    (sr_act),
        .din_i       (din_i),
        .init_val_i  (init_val),
        .q_o         (latch_q)
    );

    // Output selection: bypass first, then the chosen storage style.
    always_comb begin
        if (cfg.bypass) begin
            dout_o = din_i;
        end else if (cfg.latch_mode) begin
            dout_o = latch_q;
        end else begin
            dout_o = flop_q;
        end
    end

endmodule

// File: rtl/iodreg_chk.sv
module iodreg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             en_i,
    input logic             sr_i,
    input logic [WIDTH-1:0] din_i,
    input logic             cfg_latch_i,
    input logic             cfg_clk_inv_i,
    input logic             cfg_en_inv_i,
    input logic             cfg_sr_inv_i,
    input logic             cfg_sr_async_i,
    input logic             cfg_sr_set_i,
    input logic             cfg_bypass_i,
    input logic [WIDTH-1:0] dout_o
);

    logic             seen_q = 1'b0;
    logic [6:0]       cfg_vec;
    logic             en_on;
    logic             sr_on;
    logic             async_on;
    logic             plain_flop;
    logic [WIDTH-1:0] init_exp;

    always_ff @(posedge clk_i) seen_q <= 1'b1;

    always_comb begin
        cfg_vec    = {cfg_latch_i, cfg_clk_inv_i, cfg_en_inv_i, cfg_sr_inv_i,
                      cfg_sr_async_i, cfg_sr_set_i, cfg_bypass_i};
        en_on      = en_i ^ cfg_en_inv_i;
        sr_on      = sr_i ^ cfg_sr_inv_i;
        async_on   = cfg_sr_async_i & sr_on;
        plain_flop = !cfg_latch_i && !cfg_clk_inv_i && !cfg_bypass_i && !cfg_sr_async_i;
        init_exp   = {WIDTH{cfg_sr_set_i}};
    end

    // R1
    flop_capture_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
        $past(plain_flop) && plain_flop && $stable(cfg_vec) && $past(en_on && !sr_on)
        |-> dout_o == $past(din_i));

    // R1
    flop_hold_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
        $past(plain_flop) && plain_flop && $stable(cfg_vec) && $past(!en_on && !sr_on)
        |-> $stable(dout_o));

    // R6
    flop_sync_init_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
        $past(plain_flop) && plain_flop && $stable(cfg_vec) && $past(sr_on)
        |-> dout_o == $past(init_exp));

    // R8
    async_init_chk: assert property (@(posedge clk_i) disable iff (!seen_q)
        async_on && !cfg_bypass_i |-> dout_o == init_exp);

    // R4
    latch_follow_chk: assert property (@(negedge clk_i) disable iff (!seen_q)
        cfg_latch_i && !cfg_clk_inv_i && !cfg_bypass_i && en_on && !sr_on
        |-> dout_o == din_i);

endmodule

bind io_path_reg iodreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i          (clk_i),
    .en_i           (en_i),
    .sr_i           (sr_i),
    .din_i          (din_i),
    .cfg_latch_i    (cfg_latch_i),
    .cfg_clk_inv_i  (cfg_clk_inv_i),
    .cfg_en_inv_i   (cfg_en_inv_i),
    .cfg_sr_inv_i   (cfg_sr_inv_i),
    .cfg_sr_async_i (cfg_sr_async_i),
    .cfg_sr_set_i   (cfg_sr_set_i),
    .cfg_bypass_i   (cfg_bypass_i),
    .dout_o         (dout_o)
);

// File: tb/io_path_reg_bench.sv
`timescale 1ns/1ps
module io_path_reg_bench;

    localparam int W = 8;

    typedef struct packed {
        logic latch;
        logic clk_inv;
        logic en_inv;
        logic sr_inv;
        logic async_m;
        logic set_v;
        logic bypass;
    } bcfg_t;

    logic         clk = 1'b0;
    logic         en = 1'b0;
    logic         sr = 1'b0;
    logic [W-1:0] din = '0;
    bcfg_t        cur = '0;
    logic [W-1:0] dout;

    logic [W-1:0] mqf = '0;
    logic [W-1:0] mql = '0;
    logic         kf = 1'b0;
    logic         kl = 1'b0;
    int           n_chk = 0;
    int           n_fail = 0;

    always #2 clk = ~clk;

    io_path_reg #(.WIDTH(W)) u_io_path_reg (
        .clk_i          (clk),
        .en_i           (en),
        .sr_i           (sr),
        .din_i          (din),
        .cfg_latch_i    (cur.latch),
        .cfg_clk_inv_i  (cur.clk_inv),
        .cfg_en_inv_i   (cur.en_inv),
        .cfg_sr_inv_i   (cur.sr_inv),
        .cfg_sr_async_i (cur.async_m),
        .cfg_sr_set_i   (cur.set_v),
        .cfg_bypass_i   (cur.bypass),
        .dout_o         (dout)
    );

    function automatic logic [W-1:0] init_of(input bcfg_t c);
        return {W{c.set_v}};
    endfunction

    // Reference rules, written from the requirements.
    task automatic edge_rule();
        if (sr ^ cur.sr_inv) begin
            mqf = init_of(cur); kf = 1'b1;
        end else if (en ^ cur.en_inv) begin
            mqf = din; kf = 1'b1;
        end
    endtask

    task automatic level_rule();
        if (sr ^ cur.sr_inv) begin
            mql = init_of(cur); kl = 1'b1;
        end else if (en ^ cur.en_inv) begin
            mql = din; kl = 1'b1;
        end
    endtask

    task automatic async_rule();
        if (cur.async_m && (sr ^ cur.sr_inv)) begin
            mqf = init_of(cur); kf = 1'b1;
            mql = init_of(cur); kl = 1'b1;
        end
    endtask

    task automatic check(input string tag);
        logic [W-1:0] exp_v;
        logic         known;
        if (cur.bypass) begin
            exp_v = din; known = 1'b1;
        end else if (cur.latch) begin
            exp_v = mql; known = kl;
        end else begin
            exp_v = mqf; known = kf;
        end
        if (known) begin
            n_chk++;
            if (dout !== exp_v) begin
                n_fail++;
                $display("FAIL %s: dout=%h expected %h at %0t", tag, dout, exp_v, $time);
            end
        end
    endtask

    function automatic string auto_tag(input bcfg_t c, input logic e, input logic s);
        logic s_on;
        s_on = s ^ c.sr_inv;
        if (c.bypass) return "R10";
        if (c.async_m && s_on) return "R8";
        if (c.latch) return s_on ? "R7" : (c.clk_inv ? "R2" : "R4");
        if (s_on) return "R6";
        if (c.clk_inv) return "R2";
        if (c.en_inv || (e == 1'b0)) return "R3";
        return "R1";
    endfunction

    // One clock period: falling edge, drive, low-phase check, rising edge, high-phase check.
    task automatic step(input bcfg_t c, input logic [W-1:0] d, input logic e,
                        input logic s, input string tag);
        @(negedge clk);
        if (cur.clk_inv) begin
            edge_rule();
            level_rule();
        end
        #0.5;
        if (c != cur) begin
            kf = 1'b0;
            kl = 1'b0;
        end
        cur = c; din = d; en = e; sr = s;
        async_rule();
        if (cur.clk_inv) level_rule();
        #1;
        check(tag);
        @(posedge clk);
        if (!cur.clk_inv) begin
            edge_rule();
            level_rule();
        end
        async_rule();
        #1.5;
        check(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        bcfg_t c;
        void'($urandom(32'd20240611));

        // R8: immediate clear from the all-zero configuration is the power-up state
        c = '0; c.async_m = 1'b1;
        step(c, 8'h5A, 1'b1, 1'b1, "R8");
        step(c, 8'hFF, 1'b0, 1'b0, "R8");
        // R1: capture on the rising edge
        step(c, 8'h3C, 1'b1, 1'b0, "R1");
        step(c, 8'h81, 1'b0, 1'b0, "R1");
        // R9: set loads all ones
        c.set_v = 1'b1;
        step(c, 8'h00, 1'b0, 1'b1, "R9");
        // R6: synchronous set beats data and enable
        c.async_m = 1'b0;
        step(c, 8'h00, 1'b1, 1'b1, "R6");
        c.set_v = 1'b0;
        step(c, 8'h77, 1'b0, 1'b1, "R6");
        step(c, 8'h77, 1'b0, 1'b1, "R9");
        // R3: inverted enable
        c.en_inv = 1'b1;
        step(c, 8'hC3, 1'b0, 1'b0, "R3");
        step(c, 8'h11, 1'b1, 1'b0, "R3");
        // R5: inverted set/reset
        c.sr_inv = 1'b1; c.set_v = 1'b1;
        step(c, 8'h12, 1'b1, 1'b0, "R5");
        step(c, 8'h42, 1'b0, 1'b1, "R5");
        // R2: falling-edge flip-flop
        c = '0; c.clk_inv = 1'b1;
        step(c, 8'h99, 1'b1, 1'b0, "R2");
        step(c, 8'h00, 1'b0, 1'b0, "R2");
        step(c, 8'h66, 1'b0, 1'b0, "R2");
        // R4: transparent latch, then hold
        c = '0; c.latch = 1'b1;
        step(c, 8'h5C, 1'b1, 1'b0, "R4");
        step(c, 8'hA0, 1'b0, 1'b0, "R4");
        // R7: synchronous clear ignored while closed, applied while open
        step(c, 8'hEE, 1'b1, 1'b1, "R7");
        // R2: latch open while the clock is low
        c.clk_inv = 1'b1;
        step(c, 8'h6B, 1'b1, 1'b0, "R2");
        step(c, 8'h6B, 1'b1, 1'b0, "R2");
        // R10: bypass
        c.bypass = 1'b1;
        step(c, 8'hDB, 1'b0, 1'b1, "R10");
        step(c, 8'h24, 1'b1, 1'b0, "R10");

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] d;
            logic         e;
            logic         s;
            if (($urandom % 20) == 0) c = bcfg_t'($urandom);
            d = W'($urandom);
            e = 1'($urandom);
            s = (($urandom % 6) == 0) ? ~c.sr_inv : c.sr_inv;
            step(c, d, e, s, auto_tag(c, e, s));
        end

        finish_run();
    end

endmodule